// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns single register accesses from a host into timed bus cycles on an 8-bit asynchronous NAND flash interface. Writing the command select issues one byte with the command latch (CLE) raised. Writing the address select issues one byte with the address latch (ALE) raised. Writing the data select issues a plain data byte. Reading the data select runs one read strobe and keeps the captured byte for the host to collect once the cycle has finished.

Every cycle has three phases: a setup phase, an active-low strobe phase and a hold phase. One 32-bit timing word sets the length of each phase, with separate values for the read strobe and the write strobe. An optional ready-wait follows the hold phase. It keeps the cycle open for a programmed number of clocks and then until the device reports ready through a two-flop synchroniser.

A configuration bit can hold chip enable low between cycles. A control bit resets the whole block at once, even in the middle of a cycle.

Top module: `nfc_bus_seq`

## Requirements
- R1: After reset the pins are idle: `nand_ce_n` high, `nand_cle` and `nand_ale` low, both strobes high, `nand_dq_oe` low. `host_busy` is low. The timing word, the configuration bit and the captured byte read back as 0.
- R2: The timing word (select 4) holds eight 4-bit fields. The read fields are setup at bit 0, hold at bit 4, width at bit 8 and ready-wait at bit 12. The write fields are setup at bit 16, hold at bit 20, width at bit 24 and ready-wait at bit 28. The word reads back exactly as written.
- R3: A setup, width or hold field of value N lasts N+1 clocks. Each cycle runs setup, then the strobe low for the width phase, then hold. The two strobes are never low together.
- R4: Command writes (select 2) raise CLE and address writes (select 1) raise ALE, each for the setup, strobe and hold phases. Data writes (select 0) raise neither latch. For all three write kinds, bits 7:0 of the write data are driven on `nand_dq_out` with `nand_dq_oe` high through setup, strobe and hold.
- R5: A read of select 0 while idle runs a read cycle with `nand_re_n` low for the width phase and the output driver off. `nand_dq_in` is captured on the last clock of the strobe phase. A later read of select 0 returns that byte in bits 7:0, with the upper bits zero.
- R6: When the ready-wait field N is non-zero, the cycle stays busy for 2*N clocks after the hold phase, with both strobes high and the latches low. It then stays busy until the synchronised ready level is high. When N is zero the cycle ends after the hold phase.
- R7: The ready input passes through two flops. The status value (select 5, bit 0) equals `nand_rb` as it stood two clock edges earlier.
- R8: Bit 0 of the configuration word (select 3) set to 1 holds `nand_ce_n` low while idle. When that bit is 0, `nand_ce_n` is high while idle. `nand_ce_n` is low throughout every cycle.
- R9: `host_busy` is high from the clock after a cycle is accepted until the cycle ends. While it is high, host writes and reads other than a control write have no effect.
- R10: A control write (select 6) with bit 0 set ends any cycle on that edge. It clears the timing word, the configuration bit and the captured byte, whether or not the block is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_sel | input | 3 | Register select for the access |
| host_wr | input | 1 | Write strobe, one clock per access |
| host_rd | input | 1 | Read strobe, one clock per access |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for the current select |
| host_busy | output | 1 | A bus cycle is in progress |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Byte driven to the device |
| nand_dq_oe | output | 1 | Output enable for `nand_dq_out` |
| nand_dq_in | input | 8 | Byte from the device |
| nand_rb | input | 1 | Device ready (high) or busy (low) |

## Verification
The assertions check the pin rules on every clock:
- the two strobes are never low together, and neither is CLE with ALE;
- chip enable is low under any strobe;
- the bus is quiet whenever the block is not busy;
- the read strobe never coincides with the output driver;
- the status bit trails the ready pin by exactly two edges;
- a soft reset leaves the block idle on the next clock.

The lengths of the setup, strobe, hold and ready-wait phases, the byte captured at the end of a read, and the discarding of accesses made while busy can only be shown by the bench's scenarios. A behavioural model in the bench predicts each of these clock by clock.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  localparam int FIELD_W = 4;
  localparam int CNT_W   = FIELD_W + 1;
  localparam int SEL_W   = 3;

  localparam logic [SEL_W-1:0] SEL_DATA   = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_ADDR   = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_CMD    = SEL_W'(2);
  localparam logic [SEL_W-1:0] SEL_CFG    = SEL_W'(3);
  localparam logic [SEL_W-1:0] SEL_TIMING = SEL_W'(4);
  localparam logic [SEL_W-1:0] SEL_STATUS = SEL_W'(5);
  localparam logic [SEL_W-1:0] SEL_CTRL   = SEL_W'(6);

  typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_RWAIT} phase_e;
  typedef enum logic [1:0] {CY_CMD, CY_ADDR, CY_WDATA, CY_RDATA} cyc_e;

  // One direction's timing; the first member is the most significant nibble.
  typedef struct packed {
    logic [FIELD_W-1:0] rdy_wait;
    logic [FIELD_W-1:0] width;
    logic [FIELD_W-1:0] hold;
    logic [FIELD_W-1:0] setup;
  } edge_tmg_t;

  // Counter preload for a phase of n+1 clocks (counts down to zero).
  function automatic logic [CNT_W-1:0] phase_load(input logic [FIELD_W-1:0] n);
    return CNT_W'(n);
  endfunction

  // Counter preload for a ready-wait of 2*n clocks, n > 0.
  function automatic logic [CNT_W-1:0] wait_load(input logic [FIELD_W-1:0] n);
    return (CNT_W'(n) << 1) - CNT_W'(1);
  endfunction
endpackage

// File: rtl/nfc_rb_sync.sv
module nfc_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_async,
  output logic rb_sync
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], rb_async};
  end

  assign rb_sync = sh[STAGES-1];
endmodule

// File: rtl/nfc_strobe_fsm.sv
module nfc_strobe_fsm
  import nfc_pkg::*;
#(
  parameter int DQ_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_rst,
  input  logic            start,
  input  cyc_e            start_kind,
  input  logic [DQ_W-1:0] start_byte,
  input  edge_tmg_t       rd_tmg,
  input  edge_tmg_t       wr_tmg,
  input  logic            rdy,
  input  logic [DQ_W-1:0] dq_in,
  output logic            busy,
  output logic            cle,
  output logic            ale,
  output logic            we_n,
  output logic            re_n,
  output logic            dq_oe,
  output logic [DQ_W-1:0] dq_out,
  output logic [DQ_W-1:0] rd_byte,
  output logic            strobe_end
);
  phase_e            ph;
  cyc_e              kind;
  logic [CNT_W-1:0]  cnt;
  logic [DQ_W-1:0]   wbyte_q;
  logic [DQ_W-1:0]   rbyte_q;
  edge_tmg_t         cur_t;
  logic [FIELD_W-1:0] new_setup;
  logic              cnt_zero;
  logic              on_bus;
  logic              is_rd;

  assign is_rd     = (kind == CY_RDATA);
  assign cur_t     = is_rd ? rd_tmg : wr_tmg;
  assign new_setup = (start_kind == CY_RDATA) ? rd_tmg.setup : wr_tmg.setup;
  assign cnt_zero  = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; kind <= CY_CMD; cnt <= '0; wbyte_q <= '0; rbyte_q <= '0;
    end else if (sw_rst) begin
      ph <= PH_IDLE; kind <= CY_CMD; cnt <= '0; wbyte_q <= '0; rbyte_q <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (start) begin
          ph      <= PH_SETUP;
          cnt     <= phase_load(new_setup);
          kind    <= start_kind;
          wbyte_q <= start_byte;
        end
        PH_SETUP: if (cnt_zero) begin
          ph  <= PH_STROBE;
          cnt <= phase_load(cur_t.width);
        end else cnt <= cnt - 1'b1;
        PH_STROBE: if (cnt_zero) begin
          ph  <= PH_HOLD;
          cnt <= phase_load(cur_t.hold);
          if (is_rd) rbyte_q <= dq_in;
        end else cnt <= cnt - 1'b1;
        PH_HOLD: if (cnt_zero) begin
          if (cur_t.rdy_wait != '0) begin
            ph  <= PH_RWAIT;
            cnt <= wait_load(cur_t.rdy_wait);
          end else ph <= PH_IDLE;
        end else cnt <= cnt - 1'b1;
        PH_RWAIT: if (!cnt_zero) cnt <= cnt - 1'b1;
                  else if (rdy) ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign on_bus     = (ph == PH_SETUP) || (ph == PH_STROBE) || (ph == PH_HOLD);
  assign busy       = (ph != PH_IDLE);
  assign cle        = on_bus && (kind == CY_CMD);
  assign ale        = on_bus && (kind == CY_ADDR);
  assign we_n       = !((ph == PH_STROBE) && !is_rd);
  assign re_n       = !((ph == PH_STROBE) && is_rd);
  assign dq_oe      = on_bus && !is_rd;
  assign dq_out     = wbyte_q;
  assign rd_byte    = rbyte_q;
  assign strobe_end = (ph == PH_STROBE) && cnt_zero;
endmodule

// File: rtl/nfc_host_regs.sv
module nfc_host_regs
  import nfc_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int DQ_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel,
  input  logic              wr,
  input  logic              rd,
  input  logic [HOST_W-1:0] wdata,
  input  logic              busy,
  input  logic [DQ_W-1:0]   rd_byte,
  input  logic              rdy,
  output logic [HOST_W-1:0] rdata,
  output logic              sw_rst,
  output logic              start,
  output cyc_e              start_kind,
  output logic [DQ_W-1:0]   start_byte,
  output logic              force_ce,
  output edge_tmg_t         rd_tmg,
  output edge_tmg_t         wr_tmg
);
  localparam int HALF_W = $bits(edge_tmg_t);
  localparam int TW_W   = 2 * HALF_W;

  logic [TW_W-1:0] tmg_q;
  logic            force_q;

  assign sw_rst     = wr && (sel == SEL_CTRL) && wdata[0];
  assign start_byte = wdata[DQ_W-1:0];

  always_comb begin
    start      = 1'b0;
    start_kind = CY_WDATA;
    if (!busy) begin
      if (wr) begin
        case (sel)
          SEL_CMD:  begin start = 1'b1; start_kind = CY_CMD;   end
          SEL_ADDR: begin start = 1'b1; start_kind = CY_ADDR;  end
          SEL_DATA: begin start = 1'b1; start_kind = CY_WDATA; end
          default:  start = 1'b0;
        endcase
      end else if (rd && (sel == SEL_DATA)) begin
        start      = 1'b1;
        start_kind = CY_RDATA;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmg_q <= '0; force_q <= 1'b0;
    end else if (sw_rst) begin
      tmg_q <= '0; force_q <= 1'b0;
    end else if (wr && !busy) begin
      if (sel == SEL_CFG)    force_q <= wdata[0];
      if (sel == SEL_TIMING) tmg_q   <= wdata[TW_W-1:0];
    end
  end

  assign rd_tmg   = edge_tmg_t'(tmg_q[HALF_W-1:0]);
  assign wr_tmg   = edge_tmg_t'(tmg_q[TW_W-1:HALF_W]);
  assign force_ce = force_q;

  always_comb begin
    case (sel)
      SEL_DATA:   rdata = HOST_W'(rd_byte);
      SEL_CFG:    rdata = HOST_W'(force_q);
      SEL_TIMING: rdata = HOST_W'(tmg_q);
      SEL_STATUS: rdata = HOST_W'(rdy);
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/nfc_bus_seq.sv
module nfc_bus_seq
  import nfc_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int DQ_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  host_sel,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  output logic              host_busy,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DQ_W-1:0]   nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [DQ_W-1:0]   nand_dq_in,
  input  logic              nand_rb
);
  // Named internal events, visible to the bound checker.
  logic            rdy_sync;
  logic            sw_rst_evt;
  logic            start_evt;
  logic            strobe_end_evt;
  cyc_e            start_kind;
  logic [DQ_W-1:0] start_byte;
  logic [DQ_W-1:0] rd_byte;
  logic            force_ce;
  logic            busy;
  edge_tmg_t       rd_tmg;
  edge_tmg_t       wr_tmg;

  nfc_rb_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .rb_async(nand_rb), .rb_sync(rdy_sync)
  );

  nfc_host_regs #(.HOST_W(HOST_W), .DQ_W(DQ_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(host_sel), .wr(host_wr), .rd(host_rd),
    .wdata(host_wdata), .busy(busy), .rd_byte(rd_byte), .rdy(rdy_sync),
    .rdata(host_rdata), .sw_rst(sw_rst_evt), .start(start_evt),
    .start_kind(start_kind), .start_byte(start_byte), .force_ce(force_ce),
    .rd_tmg(rd_tmg), .wr_tmg(wr_tmg)
  );

  nfc_strobe_fsm #(.DQ_W(DQ_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst_evt), .start(start_evt),
    .start_kind(start_kind), .start_byte(start_byte), .rd_tmg(rd_tmg),
    .wr_tmg(wr_tmg), .rdy(rdy_sync), .dq_in(nand_dq_in), .busy(busy),
    .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
    .dq_oe(nand_dq_oe), .dq_out(nand_dq_out), .rd_byte(rd_byte),
    .strobe_end(strobe_end_evt)
  );

  assign host_busy = busy;
  assign nand_ce_n = !(force_ce || busy);
endmodule

// File: rtl/nfc_bus_seq_chk.sv
module nfc_bus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic ce_n,
  input logic cle,
  input logic ale,
  input logic we_n,
  input logic re_n,
  input logic dq_oe,
  input logic rb,
  input logic rdy_sync,
  input logic sw_rst_evt
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age <= '0;
    else if (age != 2'd3)  age <= age + 2'd1;
  end

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));

  // R4
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  // R8
  ce_under_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !re_n || cle || ale) |-> !ce_n);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (we_n && re_n && !cle && !ale && !dq_oe));

  // R5
  read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !dq_oe);

  // R7
  rb_two_flop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (rdy_sync == $past(rb, 2)));

  // R10
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_evt |=> (!busy && ce_n));
endmodule

bind nfc_bus_seq nfc_bus_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(host_busy), .ce_n(nand_ce_n),
  .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
  .dq_oe(nand_dq_oe), .rb(nand_rb), .rdy_sync(rdy_sync),
  .sw_rst_evt(sw_rst_evt)
);

// File: tb/nfc_bus_seq_tb_top.sv
module nfc_bus_seq_tb_top;
  import nfc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  host_sel = '0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_busy;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_out;
  logic [7:0]  nand_dq_in = '0;
  logic        nand_rb = 1'b1;

  always #10 clk = ~clk;

  nfc_bus_seq dut_i (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_busy(host_busy), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct {
    bit cle, ale, we_n, re_n, oe;
    bit [7:0] dq;
    bit waitb, last_pulse, is_read;
  } beat_t;

  beat_t     mq[$];
  bit        m_force = 0;
  bit [31:0] m_tw = 0;
  bit [7:0]  m_cap = 0;
  bit        m_s1 = 0, m_s2 = 0;

  // kind: 0 command, 1 address, 2 data write, 3 data read
  function automatic void push_cycle(input int kind, input bit [7:0] b);
    bit rd;
    bit [15:0] t;
    int su, ho, wi, rw;
    beat_t x;
    rd = (kind == 3);
    t  = rd ? m_tw[15:0] : m_tw[31:16];
    su = int'(t[3:0]); ho = int'(t[7:4]); wi = int'(t[11:8]); rw = int'(t[15:12]);
    x.cle = (kind == 0); x.ale = (kind == 1); x.oe = !rd; x.dq = b;
    x.we_n = 1; x.re_n = 1; x.waitb = 0; x.last_pulse = 0; x.is_read = rd;
    for (int i = 0; i <= su; i++) mq.push_back(x);
    for (int i = 0; i <= wi; i++) begin
      beat_t y;
      y = x;
      if (rd) y.re_n = 0; else y.we_n = 0;
      y.last_pulse = (i == wi);
      mq.push_back(y);
    end
    for (int i = 0; i <= ho; i++) mq.push_back(x);
    x.cle = 0; x.ale = 0; x.oe = 0; x.waitb = 1;
    for (int i = 0; i < 2 * rw; i++) mq.push_back(x);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete(); m_force = 0; m_tw = 0; m_cap = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      bit old_s2;
      bit busy_now;
      old_s2   = m_s2;
      busy_now = (mq.size() != 0);
      if (host_wr && host_sel == SEL_CTRL && host_wdata[0]) begin
        mq.delete(); m_force = 0; m_tw = 0; m_cap = 0;
      end else if (busy_now) begin
        if (mq[0].waitb && mq.size() == 1) begin
          if (old_s2) void'(mq.pop_front());
        end else begin
          if (mq[0].last_pulse && mq[0].is_read) m_cap = nand_dq_in;
          void'(mq.pop_front());
        end
      end else if (host_wr) begin
        case (host_sel)
          SEL_CMD:    push_cycle(0, host_wdata[7:0]);
          SEL_ADDR:   push_cycle(1, host_wdata[7:0]);
          SEL_DATA:   push_cycle(2, host_wdata[7:0]);
          SEL_CFG:    m_force = host_wdata[0];
          SEL_TIMING: m_tw = host_wdata;
          default: ;
        endcase
      end else if (host_rd && host_sel == SEL_DATA) begin
        push_cycle(3, 8'h00);
      end
      m_s2 = m_s1;
      m_s1 = nand_rb;
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      beat_t e;
      bit exp_ce_n, exp_busy;
      logic [31:0] exp_rd;
      exp_busy = (mq.size() != 0);
      if (exp_busy) begin
        e = mq[0]; exp_ce_n = 0;
      end else begin
        e.cle = 0; e.ale = 0; e.we_n = 1; e.re_n = 1; e.oe = 0; e.dq = 0;
        e.waitb = 0; e.last_pulse = 0; e.is_read = 0;
        exp_ce_n = !m_force;
      end
      case (host_sel)
        SEL_DATA:   exp_rd = {24'h0, m_cap};
        SEL_CFG:    exp_rd = {31'h0, m_force};
        SEL_TIMING: exp_rd = m_tw;
        SEL_STATUS: exp_rd = {31'h0, m_s2};
        default:    exp_rd = 32'h0;
      endcase
      check(host_busy == exp_busy, "R9", "busy", 32'(host_busy), 32'(exp_busy));
      check(nand_ce_n == exp_ce_n, "R8", "ce_n", 32'(nand_ce_n), 32'(exp_ce_n));
      check(nand_cle == e.cle, "R4", "cle", 32'(nand_cle), 32'(e.cle));
      check(nand_ale == e.ale, "R4", "ale", 32'(nand_ale), 32'(e.ale));
      check(nand_we_n == e.we_n, "R3", "we_n", 32'(nand_we_n), 32'(e.we_n));
      check(nand_re_n == e.re_n, "R5", "re_n", 32'(nand_re_n), 32'(e.re_n));
      check(nand_dq_oe == e.oe, "R4", "dq_oe", 32'(nand_dq_oe), 32'(e.oe));
      if (e.oe) check(nand_dq_out == e.dq, "R4", "dq_out", 32'(nand_dq_out), 32'(e.dq));
      check(host_rdata == exp_rd, "R2", "rdata", host_rdata, exp_rd);
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wait_idle();
    while (host_busy) tick();
  endtask

  task automatic hw(input logic [2:0] s, input logic [31:0] d);
    wait_idle();
    host_sel = s; host_wdata = d; host_wr = 1'b1;
    tick();
    host_wr = 1'b0;
  endtask

  task automatic hr_data();
    wait_idle();
    host_sel = SEL_DATA; host_rd = 1'b1;
    tick();
    host_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] s, output logic [31:0] v);
    host_sel = s;
    #1;
    v = host_rdata;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL R9 watchdog: actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int lows, busyc;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    check(nand_ce_n == 1'b1 && host_busy == 1'b0 && nand_we_n && nand_re_n &&
          !nand_cle && !nand_ale && !nand_dq_oe, "R1", "idle pins",
          {26'h0, nand_ce_n, host_busy, nand_we_n, nand_re_n, nand_cle, nand_ale}, 32'h2c);
    peek(SEL_TIMING, v);
    check(v == 32'h0, "R1", "timing after reset", v, 32'h0);

    // R4 command, address, data with zero timing
    hw(SEL_TIMING, 32'h0);
    hw(SEL_CMD, 32'hFFFF_FF70);
    check(nand_cle && !nand_ale && nand_dq_oe && nand_dq_out == 8'h70, "R4", "cmd setup",
          {23'h0, nand_cle, nand_dq_out}, 32'h170);
    hw(SEL_ADDR, 32'h12);
    check(nand_ale && !nand_cle && nand_dq_out == 8'h12, "R4", "addr setup",
          {23'h0, nand_ale, nand_dq_out}, 32'h112);
    hw(SEL_DATA, 32'hA5);
    wait_idle();

    // R2 timing layout readback
    hw(SEL_TIMING, 32'h0213_0312);
    peek(SEL_TIMING, v);
    check(v == 32'h0213_0312, "R2", "timing readback", v, 32'h0213_0312);

    // R3 write phase lengths: setup 3->4, width 2->3, hold 1->2
    hw(SEL_DATA, 32'h5A);
    lows = 0; busyc = 0;
    while (host_busy) begin
      if (!nand_we_n) lows++;
      busyc++;
      tick();
    end
    check(lows == 3, "R3", "we_n low clocks", 32'(lows), 32'd3);
    check(busyc == 9, "R3", "write cycle clocks", 32'(busyc), 32'd9);

    // R5 reads: read setup 2, hold 1, width 3
    nand_dq_in = 8'h3C;
    hr_data();
    wait_idle();
    peek(SEL_DATA, v);
    check(v == 32'h3C, "R5", "read byte", v, 32'h3C);
    nand_dq_in = 8'h81;
    hr_data();
    wait_idle();
    peek(SEL_DATA, v);
    check(v == 32'h81, "R5", "second read byte", v, 32'h81);

    // R6 ready-wait 2 with device busy, then ready
    hw(SEL_TIMING, 32'h0000_2000);
    nand_rb = 1'b0;
    hr_data();
    repeat (12) tick();
    check(host_busy == 1'b1, "R6", "held while device busy", 32'(host_busy), 32'd1);
    nand_rb = 1'b1;
    wait_idle();
    hr_data();
    busyc = 0;
    while (host_busy) begin busyc++; tick(); end
    check(busyc == 7, "R6", "ready-wait cycle clocks", 32'(busyc), 32'd7);

    // R7 two-flop status
    nand_rb = 1'b0;
    tick();
    peek(SEL_STATUS, v);
    check(v == 32'h1, "R7", "status after one edge", v, 32'h1);
    tick();
    peek(SEL_STATUS, v);
    check(v == 32'h0, "R7", "status after two edges", v, 32'h0);
    nand_rb = 1'b1;
    repeat (2) tick();

    // R8 chip-enable override
    hw(SEL_CFG, 32'h1);
    tick();
    check(nand_ce_n == 1'b0, "R8", "forced ce idle", 32'(nand_ce_n), 32'd0);
    hw(SEL_CFG, 32'h0);
    tick();
    check(nand_ce_n == 1'b1, "R8", "released ce idle", 32'(nand_ce_n), 32'd1);

    // R9 accesses while busy are ignored
    hw(SEL_TIMING, 32'h0F0F_0000);
    hw(SEL_DATA, 32'h11);
    host_sel = SEL_TIMING; host_wdata = 32'h1111_1111; host_wr = 1'b1;
    tick();
    host_sel = SEL_CMD; host_wdata = 32'h99;
    tick();
    host_wr = 1'b0;
    check(host_busy == 1'b1 && !nand_cle, "R9", "busy, no command latch",
          {30'h0, host_busy, nand_cle}, 32'h2);
    wait_idle();
    peek(SEL_TIMING, v);
    check(v == 32'h0F0F_0000, "R9", "timing kept", v, 32'h0F0F_0000);

    // R10 soft reset mid-cycle
    hw(SEL_DATA, 32'h22);
    repeat (3) tick();
    host_sel = SEL_CTRL; host_wdata = 32'h1; host_wr = 1'b1;
    tick();
    host_wr = 1'b0;
    check(!host_busy && nand_ce_n && nand_we_n, "R10", "aborted to idle",
          {29'h0, host_busy, nand_ce_n, nand_we_n}, 32'h3);
    peek(SEL_TIMING, v);
    check(v == 32'h0, "R10", "timing cleared", v, 32'h0);
    repeat (3) tick();

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule